// File: doc/BRIEF.md
# Page Move-In Permission Tracker

This block decides whether a cache may bring lines from a given page into itself. A cache controller asks it one question about a page at a time, and it answers at once. Permission to move lines in comes from referencing the page. It stays in force while other traffic pushes lines out, so an evicted line may come back without a fresh reference. Any flush of the data cache, purge of the cache, or purge of the translation entry for that page revokes the permission. The permission returns only on the next reference to that page.

Revocation covers the whole system. A local flush or purge is sent to the other processors on a broadcast output. Flushes and purges that arrive from other processors reach the local table after a fixed pipeline. A sync handshake tells software when every revocation that arrived up to the request has taken effect. Only after that handshake can it treat a flushed line as gone.

The table is small and fully associative. References, and nothing else, set its replacement order. A page that has no entry counts as having no move-in permission.

Top module: `page_movein_tracker`

## Requirements
- R1: After reset, every queried page reports no permission, the broadcast output is idle and the sync acknowledge is low.
- R2: A local operation with code 0 (reference) on a page makes the query for that page report permission from the cycle after the clock edge that accepts it.
- R3: A local operation with code 1 (data-cache flush), 2 (cache purge) or 3 (translation purge) withdraws permission for that page only, from the cycle after its edge. A later reference grants it again.
- R4: Each local operation with code 1, 2 or 3 appears on the broadcast output for exactly the following cycle, carrying the same code and page. A local reference is never broadcast.
- R5: A remote operation with code 1, 2 or 3 withdraws permission for its page two edges after it is accepted. A remote reference has no effect on any page.
- R6: When a remote withdrawal takes effect on the same edge as a local reference to that page, the page ends without permission.
- R7: The table holds NUM_ENTRIES pages. A reference to a page not in the table replaces the entry whose last reference is oldest, and the replaced page loses permission.
- R8: Flushes and purges, local or remote, do not change the replacement order. A withdrawn entry keeps its age and is reused if its page is referenced again.
- R9: A sync request accepted on edge k raises the acknowledge for exactly one cycle, starting after edge k+2. Every remote withdrawal accepted on or before edge k is visible by then.
- R10: A sync request that arrives while an earlier one is still draining is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| localValid | input | 1 | Local operation present |
| localOp | input | 2 | Local operation code (0 ref, 1 flush, 2 cache purge, 3 translation purge) |
| localPage | input | PAGE_W | Page of the local operation |
| remoteValid | input | 1 | Operation from another processor present |
| remoteOp | input | 2 | Remote operation code, same encoding |
| remotePage | input | PAGE_W | Page of the remote operation |
| queryPage | input | PAGE_W | Page being asked about |
| queryOk | output | 1 | Move-in permitted for queryPage |
| bcastValid | output | 1 | Local withdrawal being broadcast |
| bcastOp | output | 2 | Code of the broadcast operation |
| bcastPage | output | PAGE_W | Page of the broadcast operation |
| syncReq | input | 1 | Sync request |
| syncDone | output | 1 | One-cycle sync acknowledge |

## Verification
The hardest situation to reach from the ports is a remote withdrawal that takes effect on the very edge where a local reference to the same page is accepted. The stimulus gets there by launching the remote operation two steps before the local reference. A second hard case is a sync request whose drain window holds a remote withdrawal still in flight, with further requests arriving in that window. Both are set up in directed steps. A long pseudo-random stream on a four-entry table with sixteen pages follows. After every edge, the bench queries all sixteen pages and compares each answer with a recency-list model.

// File: rtl/pmt_pkg.sv
`timescale 1ns/1ps
package pmt_pkg;

  // Operation codes shared by the local and remote streams.
  typedef enum logic [1:0] {
    OP_REF       = 2'd0,
    OP_FLUSH_C   = 2'd1,
    OP_PURGE_C   = 2'd2,
    OP_PURGE_TLB = 2'd3
  } pageOp_e;

  // Stages between accepting a remote operation and applying it.
  localparam int unsigned RMT_LAT = 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic localRef;
    logic localKill;
    logic remoteCap;
    logic remoteApply;
  } ctrlStrobe_t;

endpackage

// File: rtl/pmt_ctrl.sv
`timescale 1ns/1ps
module pmt_ctrl
  import pmt_pkg::*;
#(
  parameter int unsigned LAT = RMT_LAT
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        localValid,
  input  logic [1:0]  localOp,
  input  logic        remoteValid,
  input  logic [1:0]  remoteOp,
  input  logic        syncReq,
  output ctrlStrobe_t strobe,
  output logic        bcastValid,
  output logic        syncDone
);

  localparam int CNT_W = $clog2(LAT + 1);

  logic [LAT-1:0]   rmtVld;
  logic [CNT_W-1:0] drainCnt;

  always_comb begin
    strobe.localRef    = localValid && (localOp == OP_REF);
    strobe.localKill   = localValid && (localOp != OP_REF);
    // Remote references carry no meaning locally and are dropped here.
    strobe.remoteCap   = remoteValid && (remoteOp != OP_REF);
    strobe.remoteApply = rmtVld[LAT-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rmtVld     <= '0;
      bcastValid <= 1'b0;
      drainCnt   <= '0;
      syncDone   <= 1'b0;
    end else begin
      rmtVld     <= {rmtVld[LAT-2:0], strobe.remoteCap};
      bcastValid <= strobe.localKill;
      if (drainCnt != '0) begin
        drainCnt <= drainCnt - 1'b1;
        syncDone <= (drainCnt == CNT_W'(1));
      end else begin
        syncDone <= 1'b0;
        if (syncReq) drainCnt <= CNT_W'(LAT);
      end
    end
  end

endmodule

// File: rtl/pmt_datapath.sv
`timescale 1ns/1ps
module pmt_datapath
  import pmt_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PAGE_W  = 20,
  parameter int unsigned LAT     = RMT_LAT
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        localOp,
  input  logic [PAGE_W-1:0] localPage,
  input  logic [PAGE_W-1:0] remotePage,
  input  logic [PAGE_W-1:0] queryPage,
  output logic              queryOk,
  output logic [1:0]        bcastOp,
  output logic [PAGE_W-1:0] bcastPage
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PAGE_W-1:0] tag    [ENTRIES];
  logic [PAGE_W-1:0] tagN   [ENTRIES];
  logic [IDX_W-1:0]  age    [ENTRIES];
  logic [IDX_W-1:0]  ageN   [ENTRIES];
  logic [ENTRIES-1:0] vld, vldN, en, enN;
  logic [ENTRIES-1:0] localHit, queryHit;
  logic [PAGE_W-1:0] rmtPage [LAT];
  logic [IDX_W-1:0]  hitIdx, victimIdx, touchIdx;

  // Parallel tag compare for the local and query ports.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign localHit[g] = vld[g] && (tag[g] == localPage);
    assign queryHit[g] = vld[g] && en[g] && (tag[g] == queryPage);
  end

  assign queryOk = |queryHit;

  always_comb begin
    hitIdx    = '0;
    victimIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (localHit[i]) hitIdx = IDX_W'(i);
      if (age[i] == IDX_W'(ENTRIES - 1)) victimIdx = IDX_W'(i);
    end
    touchIdx = (|localHit) ? hitIdx : victimIdx;
  end

  // Next table state: reference first, then withdrawals so they win.
  always_comb begin
    tagN = tag;
    ageN = age;
    vldN = vld;
    enN  = en;
    if (strobe.localRef) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age[i] < age[touchIdx]) ageN[i] = age[i] + 1'b1;
      end
      ageN[touchIdx] = '0;
      tagN[touchIdx] = localPage;
      vldN[touchIdx] = 1'b1;
      enN[touchIdx]  = 1'b1;
    end
    if (strobe.localKill) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (localHit[i]) enN[i] = 1'b0;
      end
    end
    if (strobe.remoteApply) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (vldN[i] && (tagN[i] == rmtPage[LAT-1])) enN[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0;
        age[i] <= IDX_W'(i);
      end
      vld <= '0;
      en  <= '0;
    end else begin
      tag <= tagN;
      age <= ageN;
      vld <= vldN;
      en  <= enN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < LAT; s++) rmtPage[s] <= '0;
      bcastOp   <= '0;
      bcastPage <= '0;
    end else begin
      if (strobe.remoteCap) rmtPage[0] <= remotePage;
      for (int s = 1; s < LAT; s++) rmtPage[s] <= rmtPage[s-1];
      if (strobe.localKill) begin
        bcastOp   <= localOp;
        bcastPage <= localPage;
      end
    end
  end

endmodule

// File: rtl/page_movein_tracker.sv
`timescale 1ns/1ps
module page_movein_tracker
  import pmt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned PAGE_W      = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              localValid,
  input  logic [1:0]        localOp,
  input  logic [PAGE_W-1:0] localPage,
  input  logic              remoteValid,
  input  logic [1:0]        remoteOp,
  input  logic [PAGE_W-1:0] remotePage,
  input  logic [PAGE_W-1:0] queryPage,
  output logic              queryOk,
  output logic              bcastValid,
  output logic [1:0]        bcastOp,
  output logic [PAGE_W-1:0] bcastPage,
  input  logic              syncReq,
  output logic              syncDone
);

  ctrlStrobe_t strobe;

  pmt_ctrl #(.LAT(RMT_LAT)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .localValid (localValid),
    .localOp    (localOp),
    .remoteValid(remoteValid),
    .remoteOp   (remoteOp),
    .syncReq    (syncReq),
    .strobe     (strobe),
    .bcastValid (bcastValid),
    .syncDone   (syncDone)
  );

  pmt_datapath #(
    .ENTRIES(NUM_ENTRIES),
    .PAGE_W (PAGE_W),
    .LAT    (RMT_LAT)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .localOp   (localOp),
    .localPage (localPage),
    .remotePage(remotePage),
    .queryPage (queryPage),
    .queryOk   (queryOk),
    .bcastOp   (bcastOp),
    .bcastPage (bcastPage)
  );

endmodule

// File: rtl/pmt_checker.sv
`timescale 1ns/1ps
module pmt_checker #(
  parameter int unsigned PAGE_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              localValid,
  input logic [1:0]        localOp,
  input logic [PAGE_W-1:0] localPage,
  input logic [PAGE_W-1:0] queryPage,
  input logic              queryOk,
  input logic              bcastValid,
  input logic [1:0]        bcastOp,
  input logic [PAGE_W-1:0] bcastPage,
  input logic              syncReq,
  input logic              syncDone
);

  assert_kill_disables_R3: assert property (@(posedge clk) disable iff (!rstN)
    (localValid && localOp != 2'd0) |=> !(queryOk && queryPage == $past(localPage)));

  assert_bcast_follows_kill_R4: assert property (@(posedge clk) disable iff (!rstN)
    (localValid && localOp != 2'd0) |=>
      (bcastValid && bcastOp == $past(localOp) && bcastPage == $past(localPage)));

  assert_bcast_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    bcastValid |-> ($past(localValid) && $past(localOp) != 2'd0));

  assert_sync_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    syncDone |=> !syncDone);

  assert_sync_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    syncDone |-> $past(syncReq, 3));

endmodule

bind page_movein_tracker pmt_checker #(.PAGE_W(PAGE_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .localValid(localValid),
  .localOp   (localOp),
  .localPage (localPage),
  .queryPage (queryPage),
  .queryOk   (queryOk),
  .bcastValid(bcastValid),
  .bcastOp   (bcastOp),
  .bcastPage (bcastPage),
  .syncReq   (syncReq),
  .syncDone  (syncDone)
);

// File: tb/page_movein_tracker_test.sv
`timescale 1ns/1ps
module page_movein_tracker_test;

  localparam int N  = 4;
  localparam int PW = 4;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic localValid = 1'b0, remoteValid = 1'b0, syncReq = 1'b0;
  logic [1:0] localOp = '0, remoteOp = '0;
  logic [PW-1:0] localPage = '0, remotePage = '0, queryPage = '0;
  logic queryOk, bcastValid, syncDone;
  logic [1:0] bcastOp;
  logic [PW-1:0] bcastPage;

  page_movein_tracker #(.NUM_ENTRIES(N), .PAGE_W(PW)) uut (
    .clk(clk), .rstN(rstN),
    .localValid(localValid), .localOp(localOp), .localPage(localPage),
    .remoteValid(remoteValid), .remoteOp(remoteOp), .remotePage(remotePage),
    .queryPage(queryPage), .queryOk(queryOk),
    .bcastValid(bcastValid), .bcastOp(bcastOp), .bcastPage(bcastPage),
    .syncReq(syncReq), .syncDone(syncDone)
  );

  always #4 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // Recency list model: index 0 is the most recently referenced page.
  int lt[N];
  bit le[N];
  int lCnt = 0;
  int rq[2] = '{-1, -1};
  int sCnt = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mFind(input int p);
    for (int i = 0; i < lCnt; i++) if (lt[i] == p) return i;
    return -1;
  endfunction

  function automatic int mQuery(input int p);
    int k = mFind(p);
    return (k >= 0 && le[k]) ? 1 : 0;
  endfunction

  task automatic mRef(input int p);
    int k = mFind(p);
    if (k < 0) begin
      if (lCnt < N) lCnt++;
      k = lCnt - 1;
    end
    for (int i = k; i > 0; i--) begin
      lt[i] = lt[i-1];
      le[i] = le[i-1];
    end
    lt[0] = p;
    le[0] = 1'b1;
  endtask

  task automatic mKill(input int p);
    int k = mFind(p);
    if (k >= 0) le[k] = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < NP; p++) begin
      queryPage = PW'(p);
      #0.2;
      chk(tag, $sformatf("queryOk page %0d", p), int'(queryOk), mQuery(p));
    end
  endtask

  task automatic step(input bit lv, input int lop, input int lp,
                      input bit rv, input int rop, input int rp,
                      input bit sr, input string tag);
    bit eBV;
    bit eDone;
    localValid = lv; localOp = 2'(lop); localPage = PW'(lp);
    remoteValid = rv; remoteOp = 2'(rop); remotePage = PW'(rp);
    syncReq = sr;
    @(posedge clk);
    if (lv) begin
      if (lop == 0) mRef(lp);
      else mKill(lp);
    end
    if (rq[1] >= 0) mKill(rq[1]);
    rq[1] = rq[0];
    rq[0] = (rv && rop != 0) ? rp : -1;
    eBV = lv && (lop != 0);
    eDone = (sCnt == 1);
    if (sCnt > 0) sCnt--;
    else if (sr) sCnt = 2;
    @(negedge clk);
    localValid = 1'b0; remoteValid = 1'b0; syncReq = 1'b0;
    chk("R4", "bcastValid", int'(bcastValid), int'(eBV));
    if (eBV) begin
      chk("R4", "bcastOp", int'(bcastOp), lop);
      chk("R4", "bcastPage", int'(bcastPage), lp);
    end
    chk("R9", "syncDone", int'(syncDone), int'(eDone));
    sweep(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1", "bcastValid", int'(bcastValid), 0);
    chk("R1", "syncDone", int'(syncDone), 0);
    sweep("R1");

    // R2: references grant permission
    step(1, 0, 3, 0, 0, 0, 0, "R2");
    step(1, 0, 5, 0, 0, 0, 0, "R2");
    // R3: each withdrawal code, then re-reference
    step(1, 1, 3, 0, 0, 0, 0, "R3");
    step(1, 0, 3, 0, 0, 0, 0, "R3");
    step(1, 2, 3, 0, 0, 0, 0, "R3");
    step(1, 0, 3, 0, 0, 0, 0, "R3");
    step(1, 3, 5, 0, 0, 0, 0, "R3");
    step(1, 0, 5, 0, 0, 0, 0, "R3");

    // R5: remote withdrawal latency and ignored remote reference
    step(1, 0, 7, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 1, 7, 0, "R5");
    idle("R5");
    idle("R5");
    step(0, 0, 0, 1, 0, 9, 0, "R5");
    step(0, 0, 0, 1, 0, 3, 0, "R5");
    idle("R5");
    idle("R5");

    // R6: remote withdrawal lands with a local reference to the same page
    step(0, 0, 0, 1, 2, 3, 0, "R6");
    idle("R6");
    step(1, 0, 3, 0, 0, 0, 0, "R6");
    step(1, 0, 3, 0, 0, 0, 0, "R6");

    // R7: LRU eviction by references
    step(1, 0, 1, 0, 0, 0, 0, "R7");
    step(1, 0, 2, 0, 0, 0, 0, "R7");
    step(1, 0, 4, 0, 0, 0, 0, "R7");
    step(1, 0, 6, 0, 0, 0, 0, "R7");
    step(1, 0, 1, 0, 0, 0, 0, "R7");
    step(1, 0, 8, 0, 0, 0, 0, "R7");

    // R8: withdrawal keeps age; a withdrawn oldest entry is evicted next
    step(1, 1, 4, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 3, 6, 0, "R8");
    idle("R8");
    idle("R8");
    step(1, 0, 10, 0, 0, 0, 0, "R8");
    step(1, 0, 6, 0, 0, 0, 0, "R8");

    // R9: sync with a remote withdrawal in flight
    step(0, 0, 0, 1, 1, 1, 1, "R9");
    idle("R9");
    idle("R9");
    idle("R9");
    // R10: requests during drain are ignored
    step(1, 0, 12, 0, 0, 0, 1, "R10");
    step(0, 0, 0, 0, 0, 0, 1, "R10");
    step(0, 0, 0, 0, 0, 0, 1, "R10");
    step(0, 0, 0, 0, 0, 0, 1, "R10");
    idle("R10");
    idle("R10");
    idle("R10");

    // Pseudo-random stream
    seed = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      bit lv, rv, sr;
      int lop, lp, rop, rp;
      seed = seed * 32'd1103515245 + 32'd12345;
      lv  = seed[17] | seed[18];
      lop = seed[19] ? 0 : int'(seed[21:20]);
      lp  = int'(seed[25:22]);
      rv  = seed[26] & seed[27];
      rop = int'(seed[29:28]);
      rp  = int'(seed[13:10]);
      sr  = (seed[16:14] == 3'd0);
      step(lv, lop, lp, rv, rop, rp, sr, "R7");
    end
    idle("R8");
    idle("R8");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule